// File: doc/BRIEF.md
# Row-Skipping Unsigned Array Multiplier

This block is a purely combinational unsigned multiplier built as an array of full-adder rows. Each row handles one bit of the multiplier operand (the multiplicator). A row adds its partial product, which is the multiplicand ANDed with that bit, to the running sum handed down from the row above. Within each row the carries ripple sideways, so every row hands down a fully resolved sum one bit wider than the operands.

When a multiplicator bit is zero, its row has nothing to add. Its full adders are then fenced off: their operand inputs are forced to zero by isolation AND gates, so they see no switching. A multiplexer per bit forwards the incoming sum unchanged and forces the carry to zero. When the bit is one, the multiplexers select the adders' normal sum and carry. Only the multiplicator selects rows; the multiplicand never does.

A small control module turns the multiplicator bits into per-row strobes (enable and isolate). The datapath module holds the rows. The product's low bits are taken from the least significant sum bit of each row in turn. The upper half comes from the last row's sum and its carry chain.

Top module: `rowbyp_mult`

## Requirements
- R1: `product` equals the unsigned product `mcand * mplier` for every pair of operand values.
- R2: Product bit 0 equals `mcand[0] AND mplier[0]`, formed by the first row, whose partial product is the multiplicand ANDed with multiplicator bit 0.
- R3: A row whose multiplicator bit is 0 outputs the sum received from above unchanged, with a zero carry-out. A multiplicator with some zero bits therefore yields exactly the sum of the rows whose bits are 1.
- R4: In a row whose multiplicator bit is 0, every full-adder operand input (partial-product bit, upper-sum bit, carry-in) is held at 0. A one-hot multiplicator at bit j gives `mcand << j`.
- R5: A row whose multiplicator bit is 1 outputs the upper sum plus its partial product. An all-ones multiplicator gives `mcand * (2^WIDTH - 1)`.
- R6: A zero multiplicator gives a zero product for any multiplicand, with every row bypassed.
- R7: At WIDTH 4, operands 1111 and 1001 give 10000111 (135). Rows 1 and 2 are bypassed, and rows 0 and 3 are active.
- R8: All-ones operands give `(2^WIDTH - 1)^2`, which fits in the 2*WIDTH-bit product.
- R9: A zero multiplicand gives a zero product for any multiplicator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | WIDTH | Unsigned multiplicand |
| mplier | input | WIDTH | Unsigned multiplicator; bit j enables adder row j |
| product | output | 2*WIDTH | Unsigned product |

## Verification
The bench builds two copies of the multiplier. One uses the default WIDTH of 4 and the other uses WIDTH 6. Both are swept exhaustively, 256 and 4096 operand pairs, against a behavioural integer multiply. The 4-bit copy also covers the named corner patterns: all-zero and all-ones operands, one-hot multiplicators and the 1111 by 1001 example. The 6-bit copy brings the longer carry chains within reach, and with them runs of several consecutive bypassed rows that a 4-bit array cannot show.

// File: rtl/rowbyp_pkg.sv
package rowbyp_pkg;
  // Per-row strobes from control to datapath.
  typedef struct packed {
    logic rowEn;    // select adder results
    logic isolate;  // force adder operands to zero
  } rowStrobeT;
endpackage

// File: rtl/rowbyp_fa_cell.sv
module rowbyp_fa_cell (
  input  logic opA,
  input  logic opB,
  input  logic carryIn,
  output logic sumOut,
  output logic carryOut
);
  logic halfSum;
  assign halfSum  = opA ^ opB;
  assign sumOut   = halfSum ^ carryIn;
  assign carryOut = (opA & opB) | (halfSum & carryIn);
endmodule

// File: rtl/rowbyp_ctrl.sv
module rowbyp_ctrl
  import rowbyp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] mplier,
  output rowStrobeT [WIDTH-1:0] strobes
);
  // Row j is governed only by multiplicator bit j.
  for (genvar j = 0; j < WIDTH; j++) begin : gRowCtl
    assign strobes[j].rowEn   = mplier[j];
    assign strobes[j].isolate = ~mplier[j];
  end
endmodule

// File: rtl/rowbyp_row.sv
module rowbyp_row
  import rowbyp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  rowStrobeT        strobe,
  input  logic [WIDTH-1:0] ppIn,     // partial product for this row
  input  logic [WIDTH-1:0] upperIn,  // sum handed down from the row above
  output logic [WIDTH:0]   rowOut
);
  logic [WIDTH-1:0] opX;
  logic [WIDTH-1:0] opY;
  logic [WIDTH-1:0] opC;
  logic [WIDTH-1:0] faSum;
  logic [WIDTH-1:0] faCarry;
  logic [WIDTH-1:0] sumSel;
  logic [WIDTH:0]   chain;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : gCell
    // operand isolation in place of tristate gates
    assign opX[i] = ppIn[i]    & ~strobe.isolate;
    assign opY[i] = upperIn[i] & ~strobe.isolate;
    assign opC[i] = chain[i]   & ~strobe.isolate;

    rowbyp_fa_cell uFa (
      .opA      (opX[i]),
      .opB      (opY[i]),
      .carryIn  (opC[i]),
      .sumOut   (faSum[i]),
      .carryOut (faCarry[i])
    );

    // bypass multiplexers: pass upper sum, clear carry
    assign sumSel[i]   = strobe.rowEn ? faSum[i]   : upperIn[i];
    assign chain[i+1]  = strobe.rowEn ? faCarry[i] : 1'b0;
  end

  assign rowOut = {chain[WIDTH], sumSel};
endmodule

// File: rtl/rowbyp_datapath.sv
module rowbyp_datapath
  import rowbyp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]   mcand,
  input  rowStrobeT [WIDTH-1:0] strobes,
  output logic [2*WIDTH-1:0] product
);
  localparam int RowW = WIDTH + 1;

  logic [RowW-1:0]  stage [WIDTH];
  logic [WIDTH-1:0] upper [WIDTH];
  logic [WIDTH-1:0] pp    [WIDTH];

  for (genvar j = 0; j < WIDTH; j++) begin : gRow
    assign pp[j] = mcand & {WIDTH{strobes[j].rowEn}};

    if (j == 0) begin : gSeed
      assign upper[j] = '0;
    end else begin : gChain
      assign upper[j] = stage[j-1][RowW-1:1];
    end

    rowbyp_row #(.WIDTH(WIDTH)) uRow (
      .strobe  (strobes[j]),
      .ppIn    (pp[j]),
      .upperIn (upper[j]),
      .rowOut  (stage[j])
    );

    assign product[j] = stage[j][0];
  end

  // last row's sum and carry chain give the upper product bits
  assign product[2*WIDTH-1:WIDTH] = stage[WIDTH-1][RowW-1:1];
endmodule

// File: rtl/rowbyp_mult.sv
module rowbyp_mult
  import rowbyp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] product
);
  rowStrobeT [WIDTH-1:0] strobes;

  rowbyp_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .mplier  (mplier),
    .strobes (strobes)
  );

  rowbyp_datapath #(.WIDTH(WIDTH)) uDp (
    .mcand   (mcand),
    .strobes (strobes),
    .product (product)
  );
endmodule

// File: rtl/rowbyp_mult_chk.sv
module rowbyp_mult_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0]   mcand,
  input logic [WIDTH-1:0]   mplier,
  input logic [2*WIDTH-1:0] product
);
  logic [2*WIDTH-1:0] refProd;
  assign refProd = {{WIDTH{1'b0}}, mcand} * {{WIDTH{1'b0}}, mplier};

  always_comb begin
    assert_product_R1: assert (product == refProd)
      else $error("R1 product mismatch");
    assert_lsb_R2: assert (product[0] == (mcand[0] & mplier[0]))
      else $error("R2 lsb mismatch");
    if (mplier == '0) begin
      assert_zero_mplier_R6: assert (product == '0)
        else $error("R6 nonzero product");
    end
    if (mcand == '0) begin
      assert_zero_mcand_R9: assert (product == '0)
        else $error("R9 nonzero product");
    end
  end
endmodule

module rowbyp_row_chk
  import rowbyp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input rowStrobeT        strobe,
  input logic [WIDTH-1:0] ppIn,
  input logic [WIDTH-1:0] upperIn,
  input logic [WIDTH:0]   rowOut,
  input logic [WIDTH-1:0] gx,
  input logic [WIDTH-1:0] gy,
  input logic [WIDTH-1:0] gc
);
  always_comb begin
    if (!strobe.rowEn) begin
      assert_bypass_pass_R3: assert (rowOut == {1'b0, upperIn})
        else $error("R3 bypass row altered sum");
      assert_isolated_R4: assert ((gx | gy | gc) == '0)
        else $error("R4 adder inputs toggled in bypassed row");
    end else begin
      assert_active_add_R5: assert (rowOut == ({1'b0, upperIn} + {1'b0, ppIn}))
        else $error("R5 active row sum wrong");
    end
  end
endmodule

bind rowbyp_mult rowbyp_mult_chk #(.WIDTH(WIDTH)) uMultChk (
  .mcand   (mcand),
  .mplier  (mplier),
  .product (product)
);

bind rowbyp_row rowbyp_row_chk #(.WIDTH(WIDTH)) uRowChk (
  .strobe  (strobe),
  .ppIn    (ppIn),
  .upperIn (upperIn),
  .rowOut  (rowOut),
  .gx      (opX),
  .gy      (opY),
  .gc      (opC)
);

// File: tb/tb_rowbyp_mult.sv
`timescale 1ns/1ps
module tb_rowbyp_mult;
  localparam int W4 = 4;
  localparam int W6 = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [W4-1:0]   a4, b4;
  logic [2*W4-1:0] p4;
  logic [W6-1:0]   a6, b6;
  logic [2*W6-1:0] p6;

  rowbyp_mult #(.WIDTH(W4)) dut (
    .mcand (a4), .mplier (b4), .product (p4)
  );
  rowbyp_mult #(.WIDTH(W6)) dutWide (
    .mcand (a6), .mplier (b6), .product (p6)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference: integer multiply
  function automatic int refMul(int x, int y);
    return x * y;
  endfunction

  task automatic check(string tag, int got, int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, expv);
    end
  endtask

  // drive after the rising edge, sample at the falling edge
  task automatic apply4(int x, int y, string tag);
    @(posedge clk);
    #1;
    a4 = x[W4-1:0];
    b4 = y[W4-1:0];
    @(negedge clk);
    check(tag, int'(p4), refMul(x, y));
  endtask

  task automatic apply6(int x, int y, string tag);
    @(posedge clk);
    #1;
    a6 = x[W6-1:0];
    b6 = y[W6-1:0];
    @(negedge clk);
    check(tag, int'(p6), refMul(x, y));
  endtask

  initial begin
    a4 = '0; b4 = '0; a6 = '0; b6 = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // idle state: zero operands give zero product (R6)
    check("R6 idle", int'(p4), 0);
    check("R6 idle wide", int'(p6), 0);

    apply4(15, 9, "R7 1111x1001");
    check("R7 value", int'(p4), 135);
    apply4(15, 15, "R8 all ones");
    apply6(63, 63, "R8 all ones wide");
    for (int y = 0; y < 16; y++) apply4(0, y, "R9 zero mcand");
    for (int x = 0; x < 16; x++) apply4(x, 0, "R6 zero mplier");
    for (int x = 0; x < 16; x++) begin
      for (int j = 0; j < W4; j++) apply4(x, 1 << j, "R4 one-hot row");
    end
    for (int x = 0; x < 16; x++) apply4(x, 15, "R5 all rows active");
    apply4(13, 5, "R3 rows 1,3 bypassed");
    apply4(11, 10, "R3 rows 0,2 bypassed");
    apply6(45, 33, "R3 wide rows 1-4 bypassed");
    for (int x = 0; x < 16; x++) begin
      @(posedge clk);
      #1;
      a4 = x[W4-1:0];
      b4 = 4'd7;
      @(negedge clk);
      check("R2 lsb", int'(p4[0]), x & 1);
    end
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) apply4(x, y, "R1 exhaustive w4");
    end
    for (int x = 0; x < 64; x++) begin
      for (int y = 0; y < 64; y++) apply6(x, y, "R1 exhaustive w6");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule